// File: doc/BRIEF.md
# Queue Ownership Map

This block holds the table that says which function owns each of 64 hardware queues. A queue is owned either by the physical function or by one of 8 virtual functions. The lower 32 queues carry uplink traffic and the upper 32 carry downlink traffic. Software can fill the table one word at a time through a simple write port. It can also hand a whole allocation to the built-in programming engine, which clears the table, fills it and commits it without further help.

A lookup port returns the enable and the owner code for any queue index. The lookup reports nothing until the table has been committed. Any change to an entry withdraws the commit, so a half-rewritten table is never used.

The engine is a state machine with eight states:
- ST_IDLE waits for a start pulse and latches the request.
- ST_CHECK compares the requested totals against capacity.
- ST_REJECT flags an oversized request and leaves the table alone.
- ST_CLEAR marks every entry invalid in one cycle.
- ST_FILL_PF writes all 64 entries for physical-function ownership.
- ST_FILL_UL packs the uplink queues of each virtual function in turn.
- ST_FILL_DL does the same for the downlink queues.
- ST_COMMIT sets the done flag and returns to ST_IDLE.

The transitions are:
- ST_IDLE→ST_CHECK on start.
- ST_CHECK→ST_CLEAR for physical-function mode or for a request that fits.
- ST_CHECK→ST_REJECT for a request that is too large.
- ST_REJECT→ST_IDLE.
- ST_CLEAR→ST_FILL_PF or ST_CLEAR→ST_FILL_UL, by mode.
- ST_FILL_PF→ST_COMMIT after entry 63.
- ST_FILL_UL→ST_FILL_DL once all 8 functions have been walked.
- ST_FILL_DL→ST_COMMIT likewise.
- ST_COMMIT→ST_IDLE.

Top module: `qmap_top`

## Requirements
- R1: After reset every lookup returns enable 0 and owner 0, and map_done, busy, pf_mode and cfg_err are all 0. Every entry starts invalid.
- R2: While map_done is 0, every lookup returns enable 0 and owner 0, whatever the entries hold.
- R3: A write to byte address 4*q (q in 0..63, wr_addr[1:0] ignored) stores wr_data as entry q. Bit 0 is the queue enable and bits [23:16] are the owner code. Once map_done is 1, a lookup of q returns that enable and owner. A stored word of all ones is an invalid marker and looks up as disabled with owner 0.
- R4: A write to byte address 0x100 sets map_done when wr_data[0] is 1 and clears it when wr_data[0] is 0. Any entry write clears map_done on the same clock edge.
- R5: A cfg_start pulse with cfg_pf=1 first marks every entry invalid. It then fills all 64 entries with the word 0x1, so each queue is enabled with owner 0. The engine then sets map_done and drops busy.
- R6: With cfg_pf=0, uplink queues are packed from index 0 upward. Functions 0 to 7 are taken in order, and function v takes the count in cfg_ul_cnt[6v+5:6v]. Each such entry is enabled with owner 0x80+v. Uplink entries beyond the total stay invalid.
- R7: With cfg_pf=0, downlink queues are packed in the same way from index 32 upward, using cfg_dl_cnt. Downlink entries beyond the total stay invalid.
- R8: With cfg_pf=0, the request is rejected if the uplink sum exceeds 32, the downlink sum exceeds 32, or the combined sum exceeds 64. On rejection cfg_err becomes 1 and neither the table nor map_done changes. cfg_err is cleared by the next cfg_start. A request with exactly 32 queues in each half is accepted.
- R9: While busy is 1, bus writes to entries or to the done register have no effect, and cfg_start is ignored.
- R10: pf_mode is 1 exactly when at least one entry is enabled and valid and every such entry has owner code 0. This holds regardless of map_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Byte address of the write |
| wr_data | input | 32 | Write data |
| cfg_start | input | 1 | Start the programming engine |
| cfg_pf | input | 1 | 1 selects physical-function ownership of all queues |
| cfg_ul_cnt | input | 48 | Uplink queue count for each of 8 functions, 6 bits each |
| cfg_dl_cnt | input | 48 | Downlink queue count for each of 8 functions, 6 bits each |
| lk_idx | input | 6 | Queue index to look up |
| lk_en | output | 1 | Queue enabled and table committed |
| lk_owner | output | 8 | Owner code of the queue, 0 when not enabled |
| map_done | output | 1 | Table committed |
| pf_mode | output | 1 | All live entries belong to the physical function |
| busy | output | 1 | Programming engine active |
| cfg_err | output | 1 | Last request was rejected for exceeding capacity |

## Verification
A wrong engine state or a stuck packing counter shows up at the lookup port as a queue that is shifted, skipped or given to the wrong function. That becomes visible as soon as map_done rises, and the full 64-entry sweep after each allocation catches it. A done flag that survives an entry write shows at the next lookup as data returned from a table that was not committed. A capacity check that lets an oversized request through shows within a few cycles: busy stays high and cfg_err stays 0. A check that rejects too much shows the same way, with cfg_err set on the accepted 32/32 case.

// File: rtl/qmap_pkg.sv
package qmap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REJECT,
        ST_CLEAR,
        ST_FILL_PF,
        ST_FILL_UL,
        ST_FILL_DL,
        ST_COMMIT
    } qmap_state_t;

    localparam logic [7:0] VF_OWNER_BASE = 8'h80;
    localparam int         OWNER_LSB     = 16;

endpackage

// File: rtl/qmap_store.sv
module qmap_store #(
    parameter int NUM_Q  = 64,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NUM_Q)-1:0] idx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     clr_all,
    input  logic                     set_done,
    input  logic                     clr_done,
    input  logic [$clog2(NUM_Q)-1:0] lk_idx,
    output logic                     lk_en,
    output logic [7:0]               lk_owner,
    output logic                     done,
    output logic                     pf_mode
);
    import qmap_pkg::*;

    logic       en_q  [NUM_Q];
    logic       inv_q [NUM_Q];
    logic [7:0] own_q [NUM_Q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_Q; i++) begin
                en_q[i]  <= 1'b0;
                inv_q[i] <= 1'b1;
                own_q[i] <= 8'h00;
            end
        end else if (clr_all) begin
            for (int i = 0; i < NUM_Q; i++) begin
                inv_q[i] <= 1'b1;
            end
        end else if (we) begin
            en_q[idx]  <= wdata[0];
            inv_q[idx] <= &wdata;
            own_q[idx] <= wdata[OWNER_LSB +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (we || clr_all || clr_done) begin
            done <= 1'b0;
        end else if (set_done) begin
            done <= 1'b1;
        end
    end

    logic any_live;
    logic any_vf;

    always_comb begin
        any_live = 1'b0;
        any_vf   = 1'b0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (en_q[i] && !inv_q[i]) begin
                any_live = 1'b1;
                if (own_q[i] != 8'h00) begin
                    any_vf = 1'b1;
                end
            end
        end
    end

    assign pf_mode = any_live && !any_vf;

    logic live_sel;
    assign live_sel = en_q[lk_idx] && !inv_q[lk_idx];
    assign lk_en    = done && live_sel;
    assign lk_owner = lk_en ? own_q[lk_idx] : 8'h00;

    AST_WRITE_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !done); // R4

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !we) |=> (!pf_mode && !done)); // R5

endmodule

// File: rtl/qmap_engine.sv
module qmap_engine #(
    parameter int NUM_Q  = 64,
    parameter int NUM_VF = 8,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     pf_req,
    input  logic [NUM_VF*CNT_W-1:0]  ul_cnt,
    input  logic [NUM_VF*CNT_W-1:0]  dl_cnt,
    output logic                     busy,
    output logic                     cfg_err,
    output logic                     rej,
    output logic                     clr_all,
    output logic                     we,
    output logic [$clog2(NUM_Q)-1:0] idx,
    output logic [DATA_W-1:0]        wdata,
    output logic                     set_done
);
    import qmap_pkg::*;

    localparam int IDX_W = $clog2(NUM_Q);
    localparam int HALF  = NUM_Q / 2;
    localparam int VF_W  = $clog2(NUM_VF) + 1;
    localparam int SUM_W = CNT_W + VF_W + 1;

    qmap_state_t state, nxt;

    logic                    pf_q;
    logic [NUM_VF*CNT_W-1:0] ul_q, dl_q;
    logic [VF_W-1:0]         vf_q;
    logic [CNT_W-1:0]        k_q;
    logic [IDX_W-1:0]        ptr_q;

    logic [CNT_W-1:0] ul_a [NUM_VF];
    logic [CNT_W-1:0] dl_a [NUM_VF];

    for (genvar g = 0; g < NUM_VF; g++) begin : g_unpack
        assign ul_a[g] = ul_q[g*CNT_W +: CNT_W];
        assign dl_a[g] = dl_q[g*CNT_W +: CNT_W];
    end

    logic [SUM_W-1:0] ul_sum, dl_sum;
    logic             over;

    always_comb begin
        ul_sum = '0;
        dl_sum = '0;
        for (int v = 0; v < NUM_VF; v++) begin
            ul_sum = ul_sum + SUM_W'(ul_a[v]);
            dl_sum = dl_sum + SUM_W'(dl_a[v]);
        end
        over = (ul_sum > SUM_W'(HALF)) || (dl_sum > SUM_W'(HALF)) ||
               ((ul_sum + dl_sum) > SUM_W'(NUM_Q));
    end

    logic             vf_end;
    logic [CNT_W-1:0] cur_cnt;
    logic             slot_free;

    assign vf_end    = (vf_q == VF_W'(NUM_VF));
    assign cur_cnt   = (state == ST_FILL_UL) ? ul_a[vf_q[VF_W-2:0]] : dl_a[vf_q[VF_W-2:0]];
    assign slot_free = !vf_end && (k_q != cur_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_CHECK;
            ST_CHECK:   nxt = (!pf_q && over) ? ST_REJECT : ST_CLEAR;
            ST_REJECT:  nxt = ST_IDLE;
            ST_CLEAR:   nxt = pf_q ? ST_FILL_PF : ST_FILL_UL;
            ST_FILL_PF: if (ptr_q == IDX_W'(NUM_Q - 1)) nxt = ST_COMMIT;
            ST_FILL_UL: if (vf_end) nxt = ST_FILL_DL;
            ST_FILL_DL: if (vf_end) nxt = ST_COMMIT;
            ST_COMMIT:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_q    <= 1'b0;
            ul_q    <= '0;
            dl_q    <= '0;
            vf_q    <= '0;
            k_q     <= '0;
            ptr_q   <= '0;
            cfg_err <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pf_q    <= pf_req;
                        ul_q    <= ul_cnt;
                        dl_q    <= dl_cnt;
                        cfg_err <= 1'b0;
                    end
                end
                ST_REJECT: cfg_err <= 1'b1;
                ST_CLEAR: begin
                    vf_q  <= '0;
                    k_q   <= '0;
                    ptr_q <= '0;
                end
                ST_FILL_PF: ptr_q <= ptr_q + 1'b1;
                ST_FILL_UL, ST_FILL_DL: begin
                    if (vf_end) begin
                        vf_q  <= '0;
                        k_q   <= '0;
                        ptr_q <= IDX_W'(HALF);
                    end else if (k_q == cur_cnt) begin
                        vf_q <= vf_q + 1'b1;
                        k_q  <= '0;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                        k_q   <= k_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    logic [7:0] vf_owner;
    assign vf_owner = VF_OWNER_BASE + 8'(vf_q);

    always_comb begin
        busy     = (state != ST_IDLE);
        rej      = (state == ST_REJECT);
        clr_all  = (state == ST_CLEAR);
        set_done = (state == ST_COMMIT);
        idx      = ptr_q;
        we       = 1'b0;
        wdata    = '0;
        unique case (state)
            ST_FILL_PF: begin
                we    = 1'b1;
                wdata = DATA_W'(1);
            end
            ST_FILL_UL, ST_FILL_DL: begin
                we    = slot_free;
                wdata = '0;
                wdata[OWNER_LSB +: 8] = vf_owner;
                wdata[0] = 1'b1;
            end
            default: ;
        endcase
    end

    AST_UL_LOWER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL_UL && we) |-> (idx < IDX_W'(HALF))); // R6

    AST_DL_UPPER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL_DL && we) |-> (idx >= IDX_W'(HALF))); // R7

    AST_ERR_ONLY_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> ($past(over) && !$past(pf_q))); // R8

endmodule

// File: rtl/qmap_top.sv
module qmap_top #(
    parameter int NUM_Q  = 64,
    parameter int NUM_VF = 8,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = $clog2(NUM_Q) + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     cfg_start,
    input  logic                     cfg_pf,
    input  logic [NUM_VF*CNT_W-1:0]  cfg_ul_cnt,
    input  logic [NUM_VF*CNT_W-1:0]  cfg_dl_cnt,
    input  logic [$clog2(NUM_Q)-1:0] lk_idx,
    output logic                     lk_en,
    output logic [7:0]               lk_owner,
    output logic                     map_done,
    output logic                     pf_mode,
    output logic                     busy,
    output logic                     cfg_err
);
    localparam int IDX_W = $clog2(NUM_Q);
    localparam logic [ADDR_W-1:0] DONE_ADDR = ADDR_W'(NUM_Q * 4);

    logic             e_we, e_clr, e_set, e_rej;
    logic [IDX_W-1:0] e_idx;
    logic [DATA_W-1:0] e_wdata;

    qmap_engine #(
        .NUM_Q (NUM_Q),
        .NUM_VF(NUM_VF),
        .CNT_W (CNT_W),
        .DATA_W(DATA_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cfg_start),
        .pf_req  (cfg_pf),
        .ul_cnt  (cfg_ul_cnt),
        .dl_cnt  (cfg_dl_cnt),
        .busy    (busy),
        .cfg_err (cfg_err),
        .rej     (e_rej),
        .clr_all (e_clr),
        .we      (e_we),
        .idx     (e_idx),
        .wdata   (e_wdata),
        .set_done(e_set)
    );

    logic bus_ok, entry_hit, done_hit;
    assign bus_ok    = wr_en && !busy;
    assign entry_hit = bus_ok && (wr_addr < DONE_ADDR);
    assign done_hit  = bus_ok && (wr_addr == DONE_ADDR);

    logic              s_we, s_set, s_clr;
    logic [IDX_W-1:0]  s_idx;
    logic [DATA_W-1:0] s_wdata;

    assign s_we    = e_we || entry_hit;
    assign s_idx   = e_we ? e_idx : wr_addr[IDX_W+1:2];
    assign s_wdata = e_we ? e_wdata : wr_data;
    assign s_set   = e_set || (done_hit && wr_data[0]);
    assign s_clr   = done_hit && !wr_data[0];

    qmap_store #(
        .NUM_Q (NUM_Q),
        .DATA_W(DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (s_we),
        .idx     (s_idx),
        .wdata   (s_wdata),
        .clr_all (e_clr),
        .set_done(s_set),
        .clr_done(s_clr),
        .lk_idx  (lk_idx),
        .lk_en   (lk_en),
        .lk_owner(lk_owner),
        .done    (map_done),
        .pf_mode (pf_mode)
    );

    AST_DONE_RISES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(map_done) |-> !busy); // R9

    AST_REJECT_HOLDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        e_rej |=> $stable(map_done)); // R8

    AST_UNCOMMITTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!map_done) |-> (!lk_en && lk_owner == 8'h00)); // R2

endmodule

// File: tb/tb_qmap_top.sv
module tb_qmap_top;

    localparam int NQ = 64;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        cfg_start = 1'b0;
    logic        cfg_pf = 1'b0;
    logic [47:0] cfg_ul_cnt = '0;
    logic [47:0] cfg_dl_cnt = '0;
    logic [5:0]  lk_idx = '0;
    logic        lk_en;
    logic [7:0]  lk_owner;
    logic        map_done, pf_mode, busy, cfg_err;

    always #5 clk = ~clk;

    qmap_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_start(cfg_start), .cfg_pf(cfg_pf), .cfg_ul_cnt(cfg_ul_cnt),
        .cfg_dl_cnt(cfg_dl_cnt), .lk_idx(lk_idx), .lk_en(lk_en), .lk_owner(lk_owner),
        .map_done(map_done), .pf_mode(pf_mode), .busy(busy), .cfg_err(cfg_err)
    );

    typedef struct {
        int         idx;
        logic       en;
        logic [7:0] own;
        string      req;
    } item_t;

    item_t q[$];
    int    pushed = 0;
    int    popped = 0;
    int    n_chk  = 0;
    int    n_bad  = 0;
    bit    ended  = 0;

    logic       m_en  [NQ];
    logic [7:0] m_own [NQ];
    logic       m_done = 1'b0;
    logic       m_err  = 1'b0;

    function automatic logic model_pf();
        logic live = 1'b0;
        logic vf = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            if (m_en[i]) begin
                live = 1'b1;
                if (m_own[i] != 8'h00) vf = 1'b1;
            end
        end
        return live && !vf;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected lookups and compares at the port
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                lk_idx = it.idx[5:0];
                #1;
                n_chk++;
                if (lk_en !== it.en || lk_owner !== it.own) begin
                    n_bad++;
                    $display("FAIL %s lookup q%0d: actual en=%0b own=%0h expected en=%0b own=%0h",
                             it.req, it.idx, lk_en, lk_owner, it.en, it.own);
                end
                popped++;
            end
        end
    end

    task automatic push_all(string req);
        for (int i = 0; i < NQ; i++) begin
            item_t it;
            it.idx = i;
            it.en  = m_done && m_en[i];
            it.own = (m_done && m_en[i]) ? m_own[i] : 8'h00;
            it.req = req;
            q.push_back(it);
            pushed++;
        end
        while (popped != pushed) @(negedge clk);
    endtask

    task automatic check_status(string req);
        @(negedge clk);
        #2;
        chk(req, "map_done", int'(map_done), int'(m_done));
        chk(req, "cfg_err", int'(cfg_err), int'(m_err));
        chk(req, "pf_mode", int'(pf_mode), int'(model_pf()));
    endtask

    task automatic bus_wr(int addr, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = addr[8:0];
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic model_wr(int addr, logic [31:0] data);
        if (addr == 256) begin
            m_done = data[0];
        end else begin
            m_en[addr/4]  = data[0] && (data != 32'hFFFF_FFFF);
            m_own[addr/4] = data[23:16];
            m_done = 1'b0;
        end
    endtask

    task automatic model_cfg(bit pf, int ul[NV], int dl[NV]);
        int su = 0, sd = 0, p;
        for (int v = 0; v < NV; v++) begin
            su += ul[v];
            sd += dl[v];
        end
        m_err = 1'b0;
        if (!pf && (su > 32 || sd > 32 || su + sd > 64)) begin
            m_err = 1'b1;
            return;
        end
        for (int i = 0; i < NQ; i++) begin
            m_en[i] = pf;
            m_own[i] = 8'h00;
        end
        if (!pf) begin
            p = 0;
            for (int v = 0; v < NV; v++)
                for (int k = 0; k < ul[v]; k++) begin
                    m_en[p] = 1'b1; m_own[p] = 8'h80 + 8'(v); p++;
                end
            p = 32;
            for (int v = 0; v < NV; v++)
                for (int k = 0; k < dl[v]; k++) begin
                    m_en[p] = 1'b1; m_own[p] = 8'h80 + 8'(v); p++;
                end
        end
        m_done = 1'b1;
    endtask

    task automatic launch(bit pf, int ul[NV], int dl[NV]);
        @(negedge clk);
        cfg_pf = pf;
        for (int v = 0; v < NV; v++) begin
            cfg_ul_cnt[v*6 +: 6] = ul[v][5:0];
            cfg_dl_cnt[v*6 +: 6] = dl[v][5:0];
        end
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_cfg(bit pf, int ul[NV], int dl[NV]);
        launch(pf, ul, dl);
        wait_idle();
        model_cfg(pf, ul, dl);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int ul[NV];
        int dl[NV];
        for (int i = 0; i < NQ; i++) begin
            m_en[i] = 1'b0;
            m_own[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_status("R1");
        chk("R1", "busy", int'(busy), 0);
        push_all("R1");

        // R2/R3 manual entry, uncommitted then committed
        bus_wr(5*4, 32'h0081_0001); model_wr(5*4, 32'h0081_0001);
        push_all("R2");
        bus_wr(256, 32'h1); model_wr(256, 32'h1);
        push_all("R3");
        check_status("R10");

        // R4 entry write drops done; R3 all-ones marker
        bus_wr(7*4 + 2, 32'hFFFF_FFFF); model_wr(7*4, 32'hFFFF_FFFF);
        check_status("R4");
        bus_wr(256, 32'h1); model_wr(256, 32'h1);
        push_all("R3");
        bus_wr(256, 32'h0); model_wr(256, 32'h0);
        check_status("R4");

        // R5 physical-function allocation
        for (int v = 0; v < NV; v++) begin ul[v] = 4; dl[v] = 4; end
        run_cfg(1'b1, ul, dl);
        check_status("R5");
        push_all("R5");

        // R6/R7 mixed allocation with zero counts
        ul = '{4, 2, 0, 0, 3, 0, 0, 1};
        dl = '{3, 0, 5, 0, 0, 2, 0, 0};
        run_cfg(1'b0, ul, dl);
        check_status("R6");
        push_all("R7");

        // R8 uplink over capacity: table and done unchanged
        ul = '{20, 13, 0, 0, 0, 0, 0, 0};
        dl = '{1, 0, 0, 0, 0, 0, 0, 0};
        run_cfg(1'b0, ul, dl);
        check_status("R8");
        push_all("R8");

        // R8 downlink over capacity
        ul = '{1, 0, 0, 0, 0, 0, 0, 0};
        dl = '{0, 0, 0, 0, 0, 0, 10, 23};
        run_cfg(1'b0, ul, dl);
        check_status("R8");

        // R8 boundary: 32 and 32 accepted
        ul = '{32, 0, 0, 0, 0, 0, 0, 0};
        dl = '{0, 0, 0, 0, 0, 0, 16, 16};
        run_cfg(1'b0, ul, dl);
        check_status("R8");
        push_all("R6");

        // R9 bus writes during busy are ignored
        ul = '{20, 0, 0, 0, 0, 0, 0, 0};
        dl = '{0, 3, 0, 0, 0, 0, 0, 0};
        launch(1'b0, ul, dl);
        repeat (3) @(negedge clk);
        #2;
        chk("R9", "busy", int'(busy), 1);
        bus_wr(40*4, 32'h0080_0001);
        bus_wr(256, 32'h0);
        wait_idle();
        model_cfg(1'b0, ul, dl);
        check_status("R9");
        push_all("R9");

        finish_run();
    end

endmodule